// File: doc/BRIEF.md
# Page-Erase Byte Update Controller

This block models a small non-volatile page memory together with the controller that changes one byte of it. In this storage a page can only be erased as a whole, which sets every bit to 1. A program step can only pull bits from 1 to 0. Because of that, changing a single byte is a multi-step job. The controller copies the full page into a local buffer one byte per cycle and erases the page. It then patches the target byte inside the buffer and programs the page back one byte at a time. Erasing and programming are slow, so each is stretched by a parameterised cycle count.

A client starts an update with a one-cycle strobe, a byte address and a data byte. It then waits for the done pulse. Independently of the update engine, a direct read port returns any stored byte one cycle after the request. That port keeps working during an update and shows the storage as it is at that moment. Pages hold 1 KB, so the low ten address bits select the byte within a page and the bits above them select the page.

Top module: `flash_page_updater`

## Requirements
- R1: After reset `upd_busy` and `upd_done` are 0, `rd_data` is 0x00, and every stored byte reads 0xFF (erased).
- R2: When `rd_en` is 1 at a rising edge, `rd_data` shows the byte stored at `rd_addr` from that edge on. When `rd_en` is 0, `rd_data` keeps its value.
- R3: When an update completes, the byte at `upd_addr` reads `upd_data`, and every other byte of the same page reads what it held before. A bit that was 0 can therefore return to 1.
- R4: Page number is `upd_addr[ADDR_W-1:10]` and byte offset is `upd_addr[9:0]`. An update leaves every byte of every other page unchanged, and it only programs bytes of its own page.
- R5: The erase fires once, ERASE_CYC cycles after the 1024-cycle copy, and sets all 1024 bytes of the page to 0xFF. A byte reads 0xFF from then until its own program step.
- R6: Each program step stores the old byte ANDed with the buffered byte. Programming only targets bytes that are still erased, so the final page equals the patched buffer.
- R7: The controller walks idle, copy, erase, patch, program, done and back to idle, in that order only.
- R8: `upd_busy` rises in the cycle after an accepted start. It stays high for exactly 1026 + ERASE_CYC + 1024*PROG_CYC cycles (3090 with defaults).
- R9: `upd_done` is a single-cycle pulse in the last busy cycle. `upd_busy` is 0 in the following cycle.
- R10: A start strobe seen while `upd_busy` is 1 is ignored. It does not change the running update's target, and it starts no update of its own.
- R11: Direct reads issued during an update return the current storage contents. This holds both for other pages and for the target page before and after its erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_start | input | 1 | One-cycle strobe that requests a byte update |
| upd_addr | input | ADDR_W | Byte address of the update (11 bits by default) |
| upd_data | input | DATA_W | New value for the addressed byte |
| upd_busy | output | 1 | High while an update sequence runs |
| upd_done | output | 1 | One-cycle pulse that ends an update |
| rd_en | input | 1 | Direct read request |
| rd_addr | input | ADDR_W | Byte address for a direct read |
| rd_data | output | DATA_W | Registered direct read data |

## Verification
A wrong sequencer state shows up at the busy and done ports as an update length that differs from 3090 cycles. It can also show as a done pulse that is missing or doubled, and the bench measures both on every update. A buffer or address decode fault surfaces only after done, as wrong bytes read back in the target page or in the other page. A mis-timed or misdirected erase is caught earlier, within one cycle, by reads aimed just before and just after the erase edge of a running update.

// File: rtl/pgupd_pkg.sv
package pgupd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COPY    = 3'd1,
        ST_ERASE   = 3'd2,
        ST_PATCH   = 3'd3,
        ST_PROGRAM = 3'd4,
        ST_DONE    = 3'd5
    } upd_state_e;

endpackage

// File: rtl/pgupd_cell_array.sv
// Non-volatile storage model: whole-page erase to ones, program ANDs.
module pgupd_cell_array #(
    parameter int PAGE_BITS  = 10,
    parameter int PAGE_IDX_W = 1,
    parameter int DATA_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [PAGE_BITS+PAGE_IDX_W-1:0] rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    input  logic [PAGE_BITS+PAGE_IDX_W-1:0] cp_addr,
    output logic [DATA_W-1:0]               cp_data,
    input  logic                            pg_we,
    input  logic [PAGE_BITS+PAGE_IDX_W-1:0] pg_addr,
    input  logic [DATA_W-1:0]               pg_wdata,
    input  logic                            er_en,
    input  logic [PAGE_IDX_W-1:0]           er_page
);
    localparam int ADDR_W     = PAGE_BITS + PAGE_IDX_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else begin
            if (er_en) begin
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    cells[{er_page, PAGE_BITS'(i)}] <= '1;
                end
            end
            if (pg_we) begin
                cells[pg_addr] <= cells[pg_addr] & pg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            rd_data_q <= cells[rd_addr];
        end
    end

    assign rd_data = rd_data_q;
    assign cp_data = cells[cp_addr];

endmodule

// File: rtl/pgupd_page_buf.sv
// One-page scratch buffer: synchronous write, combinational read.
module pgupd_page_buf #(
    parameter int PAGE_BITS = 10,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    logic [DATA_W-1:0] slots [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/pgupd_wait_timer.sv
// Down counter shared by the erase and program latencies.
module pgupd_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_page_updater.sv
// Read-modify-write byte updater over an erase-by-page storage model.
module flash_page_updater
    import pgupd_pkg::*;
#(
    parameter int PAGE_BITS = 10,
    parameter int NUM_PAGES = 2,
    parameter int DATA_W    = 8,
    parameter int ERASE_CYC = 16,
    parameter int PROG_CYC  = 2,
    localparam int PAGE_IDX_W = $clog2(NUM_PAGES),
    localparam int ADDR_W     = PAGE_BITS + PAGE_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_start,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_data,
    output logic              upd_busy,
    output logic              upd_done,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TMR_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [PAGE_BITS-1:0] LAST_IDX = '1;

    typedef struct packed {
        upd_state_e           state;
        logic [PAGE_BITS-1:0] idx;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
    } ctl_t;

    localparam ctl_t CTL_RST = '{state: ST_IDLE, idx: '0, addr: '0, data: '0};

    ctl_t ctl_d, ctl_q;

    logic [PAGE_IDX_W-1:0] page_q;
    logic [PAGE_BITS-1:0]  offs_q;
    logic [ADDR_W-1:0]     cell_addr;
    logic [DATA_W-1:0]     cp_data;
    logic [DATA_W-1:0]     buf_rd_data;
    logic                  buf_we;
    logic [PAGE_BITS-1:0]  buf_wr_idx;
    logic [DATA_W-1:0]     buf_wr_data;
    logic                  tmr_load;
    logic [TMR_W-1:0]      tmr_val;
    logic                  tmr_en;
    logic                  tmr_expired;
    logic                  er_en;
    logic                  pg_we;
    upd_state_e            state_q;

    assign page_q    = ctl_q.addr[ADDR_W-1 -: PAGE_IDX_W];
    assign offs_q    = ctl_q.addr[PAGE_BITS-1:0];
    assign cell_addr = {page_q, ctl_q.idx};
    assign state_q   = ctl_q.state;

    always_comb begin
        ctl_d       = ctl_q;
        buf_we      = 1'b0;
        buf_wr_idx  = ctl_q.idx;
        buf_wr_data = cp_data;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        tmr_en      = 1'b0;
        er_en       = 1'b0;
        pg_we       = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (upd_start) begin
                    ctl_d.state = ST_COPY;
                    ctl_d.idx   = '0;
                    ctl_d.addr  = upd_addr;
                    ctl_d.data  = upd_data;
                end
            end
            ST_COPY: begin
                buf_we    = 1'b1;
                ctl_d.idx = ctl_q.idx + 1'b1;
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.state = ST_ERASE;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(ERASE_CYC - 1);
                end
            end
            ST_ERASE: begin
                if (tmr_expired) begin
                    er_en       = 1'b1;
                    ctl_d.state = ST_PATCH;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            ST_PATCH: begin
                buf_we      = 1'b1;
                buf_wr_idx  = offs_q;
                buf_wr_data = ctl_q.data;
                ctl_d.state = ST_PROGRAM;
                ctl_d.idx   = '0;
                tmr_load    = 1'b1;
                tmr_val     = TMR_W'(PROG_CYC - 1);
            end
            ST_PROGRAM: begin
                if (tmr_expired) begin
                    pg_we     = 1'b1;
                    ctl_d.idx = ctl_q.idx + 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PROG_CYC - 1);
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.state = ST_DONE;
                    end
                end else begin
                    tmr_en = 1'b1;
                end
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign upd_busy = (ctl_q.state != ST_IDLE);
    assign upd_done = (ctl_q.state == ST_DONE);

    pgupd_cell_array #(
        .PAGE_BITS (PAGE_BITS),
        .PAGE_IDX_W(PAGE_IDX_W),
        .DATA_W    (DATA_W)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cp_addr (cell_addr),
        .cp_data (cp_data),
        .pg_we   (pg_we),
        .pg_addr (cell_addr),
        .pg_wdata(buf_rd_data),
        .er_en   (er_en),
        .er_page (page_q)
    );

    pgupd_page_buf #(
        .PAGE_BITS(PAGE_BITS),
        .DATA_W   (DATA_W)
    ) u_buf (
        .clk    (clk),
        .wr_en  (buf_we),
        .wr_idx (buf_wr_idx),
        .wr_data(buf_wr_data),
        .rd_idx (ctl_q.idx),
        .rd_data(buf_rd_data)
    );

    pgupd_wait_timer #(
        .CNT_W(TMR_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .en      (tmr_en),
        .expired (tmr_expired)
    );

endmodule

// File: rtl/flash_page_updater_chk.sv
module flash_page_updater_chk
    import pgupd_pkg::*;
#(
    parameter int PAGE_BITS = 10,
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input upd_state_e        state,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [DATA_W-1:0] tgt_data,
    input logic [ADDR_W-1:0] pg_addr,
    input logic [DATA_W-1:0] cell_now,
    input logic              pg_we,
    input logic              er_en
);
    // R9: done lasts one cycle and is followed by idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R8: busy only rises after a start strobe
    p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R10: target held for the whole run
    p_target_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(tgt_addr) && $stable(tgt_data)));
    // R7: legal successor of each state
    p_seq_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COPY) |=> (state == ST_COPY || state == ST_ERASE));
    p_seq_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |=> (state == ST_ERASE || state == ST_PATCH));
    p_seq_patch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PATCH) |=> (state == ST_PROGRAM));
    p_seq_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROGRAM) |=> (state == ST_PROGRAM || state == ST_DONE));
    p_seq_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
    // R5: erase happens only in the erase phase and completes it
    p_erase_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        er_en |=> (state == ST_PATCH));
    // R6: each programmed byte is still erased when its step fires
    p_prog_erased_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> (cell_now == '1));
    // R4: programming stays inside the target page
    p_prog_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> (pg_addr[ADDR_W-1:PAGE_BITS] == tgt_addr[ADDR_W-1:PAGE_BITS]));

endmodule

bind flash_page_updater flash_page_updater_chk #(
    .PAGE_BITS(PAGE_BITS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (upd_start),
    .busy    (upd_busy),
    .done    (upd_done),
    .state   (state_q),
    .tgt_addr(ctl_q.addr),
    .tgt_data(ctl_q.data),
    .pg_addr (cell_addr),
    .cell_now(cp_data),
    .pg_we   (pg_we),
    .er_en   (er_en)
);

// File: tb/flash_page_updater_tb_top.sv
`timescale 1ns/1ps
module flash_page_updater_tb_top;

    localparam int PAGE_BITS = 10;
    localparam int NUM_PAGES = 2;
    localparam int DATA_W    = 8;
    localparam int ERASE_CYC = 16;
    localparam int PROG_CYC  = 2;
    localparam int ADDR_W    = 11;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int PAGE_SZ   = 1 << PAGE_BITS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_start = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic [DATA_W-1:0] upd_data = '0;
    logic              upd_busy;
    logic              upd_done;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [DATA_W-1:0] model [DEPTH];

    always #10 clk = ~clk;

    flash_page_updater #(
        .PAGE_BITS(PAGE_BITS),
        .NUM_PAGES(NUM_PAGES),
        .DATA_W   (DATA_W),
        .ERASE_CYC(ERASE_CYC),
        .PROG_CYC (PROG_CYC)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_start(upd_start),
        .upd_addr (upd_addr),
        .upd_data (upd_data),
        .upd_busy (upd_busy),
        .upd_done (upd_done),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    function automatic int exp_busy_len();
        return 2 + PAGE_SZ + ERASE_CYC + PAGE_SZ * PROG_CYC;
    endfunction

    function automatic logic [ADDR_W-1:0] other_page(input logic [ADDR_W-1:0] a);
        return a ^ ADDR_W'(PAGE_SZ);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic read_byte(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d     = rd_data;
    endtask

    task automatic read_check(input string req, input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] d;
        read_byte(a, d);
        check(req, int'(d), int'(model[a]));
    endtask

    // Runs one update from a negedge; checks busy length and the done pulse.
    task automatic run_update(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v);
        int blen = 0;
        int dcnt = 0;
        logic done_last = 1'b0;
        upd_start = 1'b1;
        upd_addr  = a;
        upd_data  = v;
        @(negedge clk);
        upd_start = 1'b0;
        while (upd_busy && blen < 10000) begin
            blen++;
            if (upd_done) dcnt++;
            done_last = upd_done;
            @(negedge clk);
        end
        check("R8 busy length", blen, exp_busy_len());
        check("R9 done count", dcnt, 1);
        check("R9 done in last busy cycle", int'(done_last), 1);
        model[a] = v;
    endtask

    initial begin : watchdog
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [DATA_W-1:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 busy after reset", int'(upd_busy), 0);
        check("R1 done after reset", int'(upd_done), 0);
        check("R1 rd_data after reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R1 erased low byte", 11'h000);
        read_check("R1 erased high byte", 11'h7FF);

        // R3/R4: first update in page 0 at offset 0x10
        run_update(11'h010, 8'h5A);
        check("R9 busy low after done", int'(upd_busy), 0);
        read_check("R3 target byte", 11'h010);
        read_check("R3 neighbour byte", 11'h011);
        read_check("R4 other page same offset", 11'h410);
        read_check("R2 direct read page1 last", 11'h7FF);

        // Seed a value in page 1 last byte
        run_update(11'h7FF, 8'h12);
        read_check("R3 page1 last byte", 11'h7FF);
        read_check("R4 page0 kept", 11'h010);

        // Directed run with mid-sequence reads and an ignored start
        upd_start = 1'b1;
        upd_addr  = 11'h410;
        upd_data  = 8'h3C;
        for (int k = 1; k < 10000; k++) begin
            @(negedge clk);
            if (k == 1) begin
                upd_addr = 11'h020;   // R10: strobe while busy
                upd_data = 8'h00;
            end
            if (k == 2) begin
                upd_start = 1'b0;
                rd_en     = 1'b1;
                rd_addr   = 11'h010;
            end
            if (k == 3) begin
                rd_en = 1'b0;
                check("R11 other page during update", int'(rd_data), 8'h5A);
            end
            if (k == 1023 + ERASE_CYC) begin
                rd_en   = 1'b1;
                rd_addr = 11'h7FF;
            end
            if (k == 1024 + ERASE_CYC)
                check("R11 target page before erase", int'(rd_data), 8'h12);
            if (k == 1026 + ERASE_CYC) begin
                rd_en = 1'b0;
                check("R5 target page erased", int'(rd_data), 8'hFF);
            end
            if (!upd_busy) break;
        end
        model[11'h410] = 8'h3C;
        check("R2 rd_data held while rd_en low", int'(rd_data), 8'hFF);
        check("R10 no second update", int'(upd_busy), 0);
        read_check("R6 programmed page restored", 11'h7FF);
        read_check("R3 patched byte", 11'h410);
        read_check("R10 ignored target untouched", 11'h020);

        // Corner values: set all bits back, clear all bits at offset 0
        run_update(11'h7FF, 8'hFF);
        read_check("R3 bits return to one", 11'h7FF);
        run_update(11'h400, 8'h00);
        read_check("R6 all bits cleared", 11'h400);
        read_check("R3 page neighbour kept", 11'h410);

        // Random updates checked against the bench model
        for (int n = 0; n < 10; n++) begin
            logic [ADDR_W-1:0] a;
            logic [ADDR_W-1:0] b;
            a = ADDR_W'($urandom % DEPTH);
            run_update(a, DATA_W'($urandom % 256));
            read_check("R3 random target", a);
            b = ADDR_W'($urandom % DEPTH);
            read_check("R3 random other byte", b);
            read_check("R4 random other page", other_page(a));
        end

        read_byte(11'h010, d);
        check("R4 page0 final", int'(d), int'(model[11'h010]));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule